// File: doc/BRIEF.md
# Priority Interrupt Controller

This block sits between four interrupt sources and a processor core. The sources are program conditions such as arithmetic overflow or division by zero, an internal timer, I/O controllers, and hardware faults such as a memory parity error. A pulse on a source's request line is held in a pending latch. A per-source mask can block that pulse. The controller then picks one pending source and raises a single request line to the core, together with a vector address that is unique to that source. The core accepts the request with an acknowledge pulse and closes its handler with an end-of-interrupt pulse.

A mode input selects one of two service disciplines. In sequential mode the core is never interrupted while a handler runs. Requests that arrive during a handler stay latched and are served afterwards, in the order in which they occurred. In nested mode a source of higher priority than every handler in service is delivered at once, even while a lower-priority handler runs. When that higher-priority handler ends, the controller resumes from the interrupted lower-priority level. The mode input is expected to change only while nothing is pending or in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is low, the vector output is zero, and no source is pending or in service.
- R2: Source indices are 0 = program condition, 1 = I/O, 2 = timer, 3 = hardware fault. The vector for source i is VEC_BASE + i * VEC_STEP. A higher index has higher priority.
- R3: An unmasked request pulse is latched on the rising edge that samples it. When the controller is free to deliver it, the request output rises on the next rising edge.
- R4: A request that arrives while its mask bit is 1 is discarded. It does not become pending when the mask bit later returns to 0.
- R5: Once raised, the request output stays high and the vector output stays unchanged until an acknowledge. An acknowledge while the request output is low has no effect.
- R6: In sequential mode, after an acknowledge no request is raised until an end-of-interrupt has been received.
- R7: In sequential mode, pending sources are served in arrival order. Sources that arrive in the same cycle are ordered higher priority first.
- R8: A request from a source that is already pending, or that is being acknowledged in the same cycle, is merged with it and produces one delivery only.
- R9: In nested mode, a pending source is delivered only if its priority is above every source in service. Sources of lower or equal priority wait.
- R10: End-of-interrupt removes the highest-priority source in service, so service returns to the interrupted lower level. An end-of-interrupt with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_SRC | Request pulse per source |
| mask_i | input | NUM_SRC | 1 blocks the corresponding request |
| nest_mode_i | input | 1 | 0 = sequential discipline, 1 = nested priority discipline |
| ack_i | input | 1 | Acknowledge from the core |
| eoi_i | input | 1 | End of interrupt from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | VEC_W | Vector address of the request being offered |

## Verification
The bench builds the controller with four sources and a four-entry arrival queue, so all four sources can be waiting at once and the queue reaches full depth. It uses a vector base of 0x40 and a step of 8, which moves every vector away from the default values and so exposes a wrong base or scale. With this queue depth the bench can wait for a handler to finish while all other sources are queued behind it. It can also stack three nested levels (I/O, then fault, then timer after the fault ends) and check the return to the I/O level.

// File: rtl/irq_prio_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes: source indices grow with priority.
package irq_prio_pkg;

    // Service discipline selected by the mode input
    typedef enum logic {
        DISC_SEQUENTIAL = 1'b0,
        DISC_NESTED     = 1'b1
    } disc_e;

    // Vector address of a source index
    function automatic int vec_addr(int base, int step, int idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
// Pending latches, one flop per source.
// A request is accepted when it is unmasked, not already pending, and not being
// cleared by an acknowledge in the same cycle (it merges with that one).
// Assumes: clr_i is one-hot or zero.
module irq_pend_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] accept_o
);

    logic [NUM_SRC-1:0] pend_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Accept a fresh, unmasked request for this source
        assign accept_o[g] = req_i[g] & ~mask_i[g] & ~pend_q[g] & ~clr_i[g];

        // Hold the pending bit of this source
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (clr_i[g])
                pend_q[g] <= 1'b0;
            else if (accept_o[g])
                pend_q[g] <= 1'b1;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_order_fifo.sv
// Arrival-order queue of source indices.
// An entry can be removed from any position. Simultaneous pushes enter with
// the highest index first.
// Assumes: DEPTH is a power of two, DEPTH >= NUM_SRC, and each source is
// pushed only while absent, so the queue never overflows.
module irq_order_fifo #(
    parameter int NUM_SRC = 4,
    parameter int DEPTH   = 4,
    parameter int SRC_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] push_i,
    input  logic               pop_en_i,
    input  logic [SRC_W-1:0]   pop_src_i,
    output logic [SRC_W-1:0]   head_o,
    output logic               empty_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = IDX_W + 1;

    logic [SRC_W-1:0] slot_q [DEPTH];
    logic [SRC_W-1:0] slot_d [DEPTH];
    logic [SRC_W-1:0] ext    [DEPTH+1];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;

    // Remove the popped source, close the gap, then append new arrivals
    always_comb begin
        for (int p = 0; p < DEPTH; p++) begin
            ext[p] = slot_q[p];
        end
        ext[DEPTH] = '0;
        slot_d     = slot_q;
        cnt_d      = cnt_q;
        hit        = 1'b0;
        for (int p = 0; p < DEPTH; p++) begin
            if (pop_en_i && !hit && (CNT_W'(p) < cnt_q) && (slot_q[p] == pop_src_i))
                hit = 1'b1;
            if (hit)
                slot_d[p] = ext[p+1];
        end
        if (hit)
            cnt_d = cnt_d - 1'b1;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (push_i[s] && (cnt_d < CNT_W'(DEPTH))) begin
                slot_d[cnt_d[IDX_W-1:0]] = SRC_W'(s);
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    // Register the queue contents and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int p = 0; p < DEPTH; p++) slot_q[p] <= '0;
        end else begin
            cnt_q  <= cnt_d;
            slot_q <= slot_d;
        end
    end

    assign head_o  = slot_q[0];
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder: returns the index of the highest set bit and
// whether any bit is set.
module irq_prio_enc #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [SRC_W-1:0]   idx_o,
    output logic               vld_o
);

    // Scan upward so that the last set bit found, the highest, wins
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bits_i[i]) begin
                idx_o = SRC_W'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Priority interrupt controller, top level.
// It latches requests, picks one source according to the selected discipline,
// offers it to the core with a vector, and tracks the sources in service.
// Assumes: nest_mode_i changes only while idle; ack_i and eoi_i are
// single-cycle pulses.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 32,
    parameter int VEC_STEP   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               nest_mode_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vector_o
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic               irq_q;
    logic [SRC_W-1:0]   cur_q;
    logic [VEC_W-1:0]   vec_q;
    logic [NUM_SRC-1:0] in_svc_q;
    logic [NUM_SRC-1:0] pend_w, accept_w, ack_set, eoi_clr;
    logic [SRC_W-1:0]   head_w, hp_idx, is_idx, nxt_src;
    logic               fifo_empty, hp_vld, is_vld, nested, ack_fire, deliver;

    irq_pend_latch #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .mask_i   (mask_i),
        .clr_i    (ack_set),
        .pend_o   (pend_w),
        .accept_o (accept_w)
    );

    irq_order_fifo #(.NUM_SRC(NUM_SRC), .DEPTH(FIFO_DEPTH), .SRC_W(SRC_W)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (accept_w),
        .pop_en_i  (ack_fire),
        .pop_src_i (cur_q),
        .head_o    (head_w),
        .empty_o   (fifo_empty)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend_enc (
        .bits_i (pend_w),
        .idx_o  (hp_idx),
        .vld_o  (hp_vld)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_svc_enc (
        .bits_i (in_svc_q),
        .idx_o  (is_idx),
        .vld_o  (is_vld)
    );

    // Decode the discipline and the core handshakes
    assign nested   = (nest_mode_i == DISC_NESTED);
    assign ack_fire = ack_i & irq_q;
    assign ack_set  = ack_fire ? (NUM_SRC'(1) << cur_q) : '0;
    assign eoi_clr  = (eoi_i && is_vld) ? (NUM_SRC'(1) << is_idx) : '0;

    // Decide whether a new request may be offered, and which source it is
    always_comb begin
        if (nested) begin
            nxt_src = hp_idx;
            deliver = !irq_q && hp_vld && (!is_vld || (hp_idx > is_idx));
        end else begin
            nxt_src = head_w;
            deliver = !irq_q && !is_vld && !fifo_empty;
        end
    end

    // Offer a request and hold its vector until the core acknowledges it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            cur_q <= '0;
            vec_q <= '0;
        end else if (ack_fire) begin
            irq_q <= 1'b0;
        end else if (deliver) begin
            irq_q <= 1'b1;
            cur_q <= nxt_src;
            vec_q <= VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(nxt_src)));
        end
    end

    // Track sources in service: set on acknowledge, clear the highest on end of interrupt
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_svc_q <= '0;
        else
            in_svc_q <= (in_svc_q & ~eoi_clr) | ack_set;
    end

    assign irq_o    = irq_q;
    assign vector_o = vec_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Temporal checks for the priority interrupt controller, attached by bind.
// Assumes: the mode input is held while anything is in service.
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input logic [NUM_SRC-1:0] mask_i,
    input logic               nest_mode_i,
    input logic               ack_i,
    input logic               eoi_i,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vector_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] in_svc,
    input logic [SRC_W-1:0]   cur
);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);

    // R5
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> $stable(vector_o));

    // R4
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & mask_i & ~pend_q) != '0) |=> ((pend_q & $past(req_i & mask_i & ~pend_q)) == '0));

    // R6
    seq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode_i && (in_svc != '0) && !irq_o) |=> !irq_o);

    // R9
    nest_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_mode_i && ack_i && irq_o && (in_svc != '0)) |-> ((in_svc >> cur) == '0));

    // R10
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (in_svc != '0) && !(ack_i && irq_o))
        |=> ($countones(in_svc) + 1 == $past($countones(in_svc))));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W),
    .VEC_W   (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .mask_i      (mask_i),
    .nest_mode_i (nest_mode_i),
    .ack_i       (ack_i),
    .eoi_i       (eoi_i),
    .irq_o       (irq_o),
    .vector_o    (vector_o),
    .pend_q      (pend_w),
    .in_svc      (in_svc_q),
    .cur         (cur_q)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the priority interrupt controller.
// Inputs are driven and outputs are sampled at falling edges.
module test_irq_prio_ctrl;

    localparam int NS = 4;
    localparam int FD = 4;
    localparam int VW = 8;
    localparam int VB = 64;
    localparam int VS = 8;

    localparam int S_PROG  = 0;
    localparam int S_IO    = 1;
    localparam int S_TIMER = 2;
    localparam int S_FAULT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req_i = '0;
    logic [NS-1:0] mask_i = '0;
    logic          nest_mode_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          eoi_i = 1'b0;
    logic          irq_o;
    logic [VW-1:0] vector_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(
        .NUM_SRC(NS), .FIFO_DEPTH(FD), .VEC_W(VW), .VEC_BASE(VB), .VEC_STEP(VS)
    ) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .nest_mode_i(nest_mode_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .irq_o(irq_o), .vector_o(vector_o)
    );

    function automatic logic [31:0] vec_of(int s);
        return 32'(VB + VS * s);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [NS-1:0] m);
        req_i = m;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic do_eoi();
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
    endtask

    // Wait for a request, check its vector, then acknowledge it
    task automatic serve(string tag, int src);
        int c = 0;
        while (!irq_o && c < 20) begin
            @(negedge clk);
            c++;
        end
        check({tag, " irq"}, 32'(irq_o), 32'd1);
        check({tag, " vector"}, 32'(vector_o), vec_of(src));
        do_ack();
        check({tag, " irq after ack"}, 32'(irq_o), 32'd0);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R1: reset state
    task automatic t_reset();
        check("R1 irq at reset", 32'(irq_o), 32'd0);
        check("R1 vector at reset", 32'(vector_o), 32'd0);
    endtask

    // R2, R3, R5: latency, vector value, hold until acknowledge
    task automatic t_latency();
        pulse(NS'(1 << S_IO));
        check("R3 irq one edge after request", 32'(irq_o), 32'd0);
        step(1);
        check("R3 irq two edges after request", 32'(irq_o), 32'd1);
        check("R2 I/O vector", 32'(vector_o), vec_of(S_IO));
        step(3);
        check("R5 irq held without ack", 32'(irq_o), 32'd1);
        check("R5 vector held without ack", 32'(vector_o), vec_of(S_IO));
        do_ack();
        check("R5 irq dropped by ack", 32'(irq_o), 32'd0);
        do_eoi();
        step(2);
    endtask

    // R4, R5, R10: masked request dropped, stray ack and stray eoi ignored
    task automatic t_mask();
        mask_i = NS'(1 << S_TIMER);
        pulse(NS'(1 << S_TIMER));
        step(4);
        check("R4 masked request not raised", 32'(irq_o), 32'd0);
        mask_i = '0;
        step(4);
        check("R4 masked request stays dropped after unmask", 32'(irq_o), 32'd0);
        do_ack();
        do_eoi();
        step(2);
        check("R5 stray ack raises nothing", 32'(irq_o), 32'd0);
        pulse(NS'(1 << S_FAULT));
        serve("R10 normal service after stray eoi", S_FAULT);
        do_eoi();
        step(2);
    endtask

    // R6, R7, R8: sequential discipline
    task automatic t_sequential();
        nest_mode_i = 1'b0;
        pulse(NS'(1 << S_PROG));
        serve("R7 first program", S_PROG);
        pulse(NS'(1 << S_FAULT));
        pulse(NS'(1 << S_IO));
        pulse(NS'((1 << S_TIMER) | (1 << S_PROG)));
        pulse(NS'(1 << S_IO));
        step(3);
        check("R6 no irq during handler", 32'(irq_o), 32'd0);
        do_eoi();
        serve("R7 order 1 fault", S_FAULT);
        pulse(NS'(1 << S_FAULT));
        step(3);
        check("R6 no irq during fault handler", 32'(irq_o), 32'd0);
        do_eoi();
        serve("R7 order 2 io", S_IO);
        do_eoi();
        serve("R7 order 3 timer before simultaneous program", S_TIMER);
        do_eoi();
        serve("R7 order 4 program", S_PROG);
        do_eoi();
        serve("R7 order 5 late fault", S_FAULT);
        do_eoi();
        step(5);
        check("R8 duplicate io merged", 32'(irq_o), 32'd0);
    endtask

    // R8: request for the source being acknowledged merges with it
    task automatic t_merge_ack();
        int c = 0;
        nest_mode_i = 1'b0;
        pulse(NS'(1 << S_TIMER));
        while (!irq_o && c < 20) begin
            @(negedge clk);
            c++;
        end
        req_i = NS'(1 << S_TIMER);
        do_ack();
        req_i = '0;
        do_eoi();
        step(5);
        check("R8 request during its own ack merged", 32'(irq_o), 32'd0);
    endtask

    // R9, R10: nested discipline
    task automatic t_nested();
        nest_mode_i = 1'b1;
        step(1);
        pulse(NS'(1 << S_IO));
        serve("R9 io first level", S_IO);
        pulse(NS'(1 << S_PROG));
        step(4);
        check("R9 lower priority waits", 32'(irq_o), 32'd0);
        pulse(NS'(1 << S_IO));
        step(4);
        check("R9 equal priority waits", 32'(irq_o), 32'd0);
        pulse(NS'(1 << S_FAULT));
        serve("R9 fault preempts io", S_FAULT);
        do_eoi();
        step(4);
        check("R10 io still in service after fault ends", 32'(irq_o), 32'd0);
        pulse(NS'(1 << S_TIMER));
        serve("R10 timer preempts resumed io", S_TIMER);
        do_eoi();
        step(3);
        check("R10 back at io level", 32'(irq_o), 32'd0);
        do_eoi();
        serve("R10 pending io after io ends", S_IO);
        do_eoi();
        serve("R10 program last", S_PROG);
        do_eoi();
        step(4);
        check("R10 nothing left", 32'(irq_o), 32'd0);
        nest_mode_i = 1'b0;
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_mask();
        t_sequential();
        t_merge_ack();
        t_nested();
        done = 1'b1;
        finish_up();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_up();
        end
    end

endmodule